// File: doc/BRIEF.md
# Weighted-Sum Threshold Logic Gate

This block is a single threshold logic unit. It has a set of binary inputs, each paired with a programmable signed weight, and one programmable signed threshold. Each input that is 1 adds its weight to a running total. The decision output is 1 when that total is greater than or equal to the threshold, and 0 otherwise. Negative weights and a zero or negative threshold are allowed, so the gate can realise functions that plain AND/OR gates cannot express directly, such as the complement of an input combined with a product term.

The weights and the threshold sit in registers. A synchronous write port loads them: it selects one entry by index and applies the new value on the next rising clock edge. The decision path from the binary inputs to the output is purely combinational, so the output follows a change on the inputs in the same cycle. Software or a higher-level controller loads a configuration once, and the gate then evaluates input patterns continuously.

Top module: `tlg_gate`

## Requirements
- R1: While reset is high, and in every cycle after reset until the first write, all weights and the threshold read as 0. The output is therefore 1 for every input pattern.
- R2: The weighted sum includes weight i exactly when input bit x_in[i] is 1. An input bit that is 0 contributes nothing.
- R3: y_out is 1 when the signed weighted sum is greater than or equal to the signed threshold, and 0 otherwise. A sum equal to the threshold gives 1.
- R4: Weights and threshold are two's-complement values of W_W bits (8 by default), so negative weights and negative thresholds are honoured.
- R5: With cfg_we high, cfg_idx = i (0 <= i < N_IN) writes cfg_data to weight i, and cfg_idx = N_IN writes the threshold. The new value affects y_out only after the next rising clock edge and not before it.
- R6: With cfg_we low, no weight and no threshold changes, whatever cfg_idx and cfg_data hold.
- R7: The sum is W_W + ceil(log2 N_IN) + 1 bits wide and cannot overflow. For example, all weights +127 with threshold -128, or all weights -128 with threshold +127, decide correctly when every input is 1.
- R8: With weights 2, 1, -4 on x_in[0], x_in[1], x_in[2] and threshold -1, y_out equals NOT x_in[2] OR (x_in[0] AND x_in[1]) for all eight input patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears weights and threshold |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | $clog2(N_IN+1) | Entry select: 0..N_IN-1 selects a weight, N_IN selects the threshold |
| cfg_data | input | W_W | Two's-complement value to write |
| x_in | input | N_IN | Binary inputs; bit i pairs with weight i |
| y_out | output | 1 | Decision: 1 when weighted sum >= threshold |

## Verification
The gate is swept over all eight input patterns under several configurations. The reset configuration shows that zero weights meet a zero threshold. The 2, 1, -4 / -1 configuration shows correct signed accumulation and the mixed-polarity function. A configuration that places the sum exactly on the threshold separates >= from >. Saturated weights of +127 and -128 against opposite-sign thresholds would expose any truncated sum width. Between configurations, writes are interleaved with cycles where cfg_we is low but cfg_idx and cfg_data are changing, and the output is compared every cycle. This catches a write that lands early, one that lands at the wrong index, and one that happens without the enable.

// File: rtl/tlg_pkg.sv
package tlg_pkg;
  // width needed to hold a sum of n signed ww-bit terms without overflow
  function automatic int sum_width(input int n, input int ww);
    return ww + $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/tlg_cfg_regs.sv
module tlg_cfg_regs #(
  parameter int N_IN  = 3,
  parameter int W_W   = 8,
  parameter int IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [W_W-1:0]             cfg_data,
  output logic [N_IN-1:0][W_W-1:0]   wt_q,
  output logic [W_W-1:0]             thr_q
);
  logic [W_W-1:0] wt_r [N_IN];
  logic [W_W-1:0] thr_r;

  for (genvar i = 0; i < N_IN; i++) begin : g_wt
    always_ff @(posedge clk) begin
      if (rst) wt_r[i] <= '0;
      else if (cfg_we && (cfg_idx == IDX_W'(i))) wt_r[i] <= cfg_data;
    end
    assign wt_q[i] = wt_r[i];

    // R5: an indexed write lands in that weight on the next edge
    p_wt_write_r5: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && (cfg_idx == IDX_W'(i))) |=> (wt_r[i] == $past(cfg_data)));
    // R6: no enable, no change
    p_wt_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !cfg_we |=> $stable(wt_r[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) thr_r <= '0;
    else if (cfg_we && (cfg_idx == IDX_W'(N_IN))) thr_r <= cfg_data;
  end
  assign thr_q = thr_r;

  p_thr_write_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_idx == IDX_W'(N_IN))) |=> (thr_r == $past(cfg_data)));
  p_thr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(thr_r));
endmodule

// File: rtl/tlg_wsum.sv
module tlg_wsum #(
  parameter int N_IN = 3,
  parameter int W_W  = 8,
  parameter int S_W  = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_IN-1:0]           x_in,
  input  logic [N_IN-1:0][W_W-1:0]  wt_q,
  output logic signed [S_W-1:0]     sum
);
  localparam int SUM_MAX = ((1 << (W_W - 1)) - 1) * N_IN;
  localparam int SUM_MIN = -(1 << (W_W - 1)) * N_IN;

  logic signed [S_W-1:0] acc [N_IN+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < N_IN; i++) begin : g_term
    logic signed [S_W-1:0] term;
    always_comb begin
      if (x_in[i]) term = {{(S_W - W_W){wt_q[i][W_W-1]}}, wt_q[i]};
      else         term = '0;
    end
    assign acc[i+1] = acc[i] + term;
  end

  assign sum = acc[N_IN];

  // R2: no active input means an empty sum
  p_zero_in_r2: assert property (@(posedge clk) disable iff (rst)
    (x_in == '0) |-> (sum == '0));
  // R7: sum stays within the range of n extreme weights
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(sum) >= SUM_MIN) && (int'(sum) <= SUM_MAX));
endmodule

// File: rtl/tlg_cmp.sv
module tlg_cmp #(
  parameter int W_W = 8,
  parameter int S_W = 11
) (
  input  logic signed [S_W-1:0] sum,
  input  logic [W_W-1:0]        thr_q,
  output logic                  y
);
  logic signed [S_W-1:0] thr_ext;
  assign thr_ext = {{(S_W - W_W){thr_q[W_W-1]}}, thr_q};
  assign y = (sum >= thr_ext);
endmodule

// File: rtl/tlg_gate.sv
module tlg_gate
  import tlg_pkg::*;
#(
  parameter int N_IN = 3,
  parameter int W_W  = 8,
  localparam int IDX_W = $clog2(N_IN + 1),
  localparam int S_W   = sum_width(N_IN, W_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [W_W-1:0]   cfg_data,
  input  logic [N_IN-1:0]  x_in,
  output logic             y_out
);
  logic [N_IN-1:0][W_W-1:0] wt_q;
  logic [W_W-1:0]           thr_q;
  logic signed [S_W-1:0]    sum;

  tlg_cfg_regs #(.N_IN(N_IN), .W_W(W_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .wt_q(wt_q), .thr_q(thr_q));

  tlg_wsum #(.N_IN(N_IN), .W_W(W_W), .S_W(S_W)) u_sum (
    .clk(clk), .rst(rst), .x_in(x_in), .wt_q(wt_q), .sum(sum));

  tlg_cmp #(.W_W(W_W), .S_W(S_W)) u_cmp (
    .sum(sum), .thr_q(thr_q), .y(y_out));

  // R3: with no active input the decision reduces to threshold <= 0
  p_allzero_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (x_in == '0) |-> (y_out == ($signed(thr_q) <= 0)));
endmodule

// File: tb/sim_tlg_gate.sv
module sim_tlg_gate;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic [2:0] x_in = '0;
  logic       y_out;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  int wm [N];
  int tm;

  always #2 clk = ~clk; // 250 MHz

  tlg_gate #(.N_IN(N), .W_W(8)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .x_in(x_in), .y_out(y_out));

  // behavioural reference: register image updated at the edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) wm[i] = 0;
      tm = 0;
    end else if (cfg_we) begin
      if (int'(cfg_idx) < N) wm[cfg_idx] = int'($signed(cfg_data));
      else if (int'(cfg_idx) == N) tm = int'($signed(cfg_data));
    end
  end

  function automatic logic model_y(input logic [2:0] x);
    int s = 0;
    for (int i = 0; i < N; i++) if (x[i]) s += wm[i];
    return (s >= tm);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s x=%b actual=%b expected=%b", req, x_in, act, exp);
    end
  endtask

  // compare against the model on every clock, mid-cycle
  always @(negedge clk) begin
    if (!rst) check(cur_req, y_out, model_y(x_in));
  end

  task automatic wr(input int idx, input int val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_data = 8'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [2:0] v);
    @(posedge clk); #1;
    x_in = v;
  endtask

  task automatic sweep();
    for (int v = 0; v < 8; v++) apply(3'(v));
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1: cleared configuration gives 1 everywhere
    cur_req = "R1";
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      @(negedge clk); #1;
      check("R1", y_out, 1'b1);
    end

    // R8 / R4 / R2: example configuration, compared to the closed form
    cur_req = "R5";
    wr(0, 2); wr(1, 1); wr(2, -4); wr(3, -1);
    cur_req = "R8";
    for (int v = 0; v < 8; v++) begin
      logic [2:0] xv = 3'(v);
      apply(xv);
      @(negedge clk); #1;
      check("R8", y_out, (~xv[2]) | (xv[0] & xv[1]));
    end

    // R6: enable low while index/data wander
    cur_req = "R6";
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      cfg_idx = 2'(k); cfg_data = 8'(8'h80 + k * 37);
      x_in = 3'(k);
    end
    sweep();

    // R3: sum exactly on the threshold (3+4 = 7)
    cur_req = "R3";
    wr(0, 3); wr(1, 4); wr(2, 1); wr(3, 7);
    apply(3'b011);
    @(negedge clk); #1; check("R3", y_out, 1'b1);
    apply(3'b010);
    @(negedge clk); #1; check("R3", y_out, 1'b0);
    apply(3'b111);
    @(negedge clk); #1; check("R3", y_out, 1'b1);
    cur_req = "R2";
    sweep();

    // R5: threshold raised while x is fixed; old value holds until the edge
    cur_req = "R5";
    apply(3'b011);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = 2'd3; cfg_data = 8'd8;
    @(negedge clk); #1; check("R5", y_out, 1'b1);
    @(posedge clk); #1; cfg_we = 1'b0;
    @(negedge clk); #1; check("R5", y_out, 1'b0);

    // R7: extreme magnitudes
    cur_req = "R7";
    wr(0, 127); wr(1, 127); wr(2, 127); wr(3, -128);
    apply(3'b111);
    @(negedge clk); #1; check("R7", y_out, 1'b1);
    sweep();
    wr(0, -128); wr(1, -128); wr(2, -128); wr(3, 127);
    apply(3'b111);
    @(negedge clk); #1; check("R7", y_out, 1'b0);
    sweep();
    wr(3, -128);
    apply(3'b111);
    @(negedge clk); #1; check("R7", y_out, 1'b0);
    apply(3'b001);
    @(negedge clk); #1; check("R7", y_out, 1'b1);
    cur_req = "R4";
    wr(3, -127);
    sweep();

    // R1: reset mid-run clears everything again
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    cur_req = "R1";
    x_in = 3'b111;
    @(negedge clk); #1; check("R1", y_out, 1'b1);
    sweep();

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule